// File: doc/BRIEF.md
# Cascadable Serial Fault Readout Port

This block gathers fault events from four power-output channels and reports them over a serial port framed by an active-low select. Each channel reports four kinds of fault, giving 16 bits in all. Each fault is signalled by a one-cycle set pulse and held in a sticky register until it is read. When select falls, the sticky bits are copied into a shift register. A summary flag is latched at the same moment: it is the OR of the 16 bits.

Before the first serial clock, the data output shows the summary flag ORed with the serial input. A fault anywhere in a chain of these ports therefore reaches the host without any shifting. Rising serial-clock edges then shift the 16 fault bits out. The first rising edge clears the sticky register. Bits arriving on the serial input are taken in on falling edges and follow the local field, so a chain of devices is read as one stream while select stays low.

The serial clock idles low and data changes on its rising edge, as in SPI mode 1, apart from the leading flag. Select, clock and serial input are synchronised into a fast system clock, and all edges are detected there. The output models an open-drain pin: a data bit plus an enable, which are resolved against a pull-up outside the block.

Top module: `fault_scan_port`

## Requirements
- R1: After reset, the output enable is 0, the gate status is 0 and the sticky register is empty.
- R2: A set pulse on any fault input sets its sticky bit. The bit holds until a read clears it.
- R3: When select falls, the sticky bits load into the shift register. A flag equal to their OR is latched and holds until the next falling edge of select.
- R4: When select falls while the serial clock is low, the gate is set. While the gate is set, the data bit equals the flag ORed with the serial input.
- R5: When select falls while the serial clock is high, the gate stays clear. The data bit then shows only the local flag, and the serial input is not passed through.
- R6: Each rising serial-clock edge while select is low presents the next field bit, and the first such edge also clears the gate. Field bit 4*c+k is sent in position 4*c+k, counting from 0. Here c is the channel (0 to 3) and k is the fault kind: 0 over-temperature, 1 short to supply, 2 short to ground, 3 open load.
- R7: The first rising edge of a frame clears the sticky register. A set pulse in that same cycle, or later in the frame, is kept for the next frame.
- R8: The serial input is sampled on each falling serial-clock edge that follows the first rising edge of a frame. The sampled bits appear on the data output from the 17th rising edge onward, in arrival order.
- R9: The output enable is 1 exactly while the synchronised select is low. After select rises, the gate stays set until the serial clock next rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_set_i | input | 16 | Fault set pulses, index 4*channel+kind |
| sck_i | input | 1 | Serial clock, idles low |
| sel_n_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data from the upstream device |
| sdo_o | output | 1 | Data bit; 0 pulls the pin low when enabled |
| sdo_en_o | output | 1 | Pin drive enable; when 0 the pin is released |
| gate_o | output | 1 | Status of the pass-through gate |

## Verification
The clearing of the sticky register on the first rising edge of a frame can land in the same system cycle as a new fault set pulse. The bench provokes this by counting the synchroniser stages from the clock change, then holding a set pulse for exactly the cycle in which the first edge is acted upon. The result is judged in the next frame: the fault must appear both in the summary flag and in its own field position. A second fault, pulsed later in the same frame, must appear alongside it.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  localparam int unsigned FSP_KINDS = 4;

  typedef enum logic [1:0] {
    FK_OVERTEMP  = 2'd0,
    FK_SHORT_SUP = 2'd1,
    FK_SHORT_GND = 2'd2,
    FK_OPEN      = 2'd3
  } fsp_kind_e;

  // Position of a fault in the sticky and serial field.
  function automatic int unsigned fsp_bit(int unsigned ch, fsp_kind_e kind);
    return ch * FSP_KINDS + int'(kind);
  endfunction

endpackage

// File: rtl/fsp_sync.sv
module fsp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned CW = W * STAGES;

  logic [CW-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[CW-W-1:0], d_i};
  end

  assign q_o = chain_q[CW-1 -: W];
endmodule

// File: rtl/fsp_sticky.sv
module fsp_sticky #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned N_KIND = 4,
  localparam int unsigned W     = N_CH * N_KIND
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)
        q[ch*N_KIND +: N_KIND] <= '0;
      else if (clr_i)
        q[ch*N_KIND +: N_KIND] <= set_i[ch*N_KIND +: N_KIND];
      else
        q[ch*N_KIND +: N_KIND] <= q[ch*N_KIND +: N_KIND] | set_i[ch*N_KIND +: N_KIND];
    end
  end

  assign q_o = q;
endmodule

// File: rtl/fsp_frame_ctl.sv
module fsp_frame_ctl (
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  input  logic sck_rise,
  input  logic sck_fall,
  input  logic sel_s,
  input  logic sel_fall,
  output logic gate_o,
  output logic shift_o,
  output logic cap_o,
  output logic first_o
);
  logic started_q;
  logic gate_q;

  assign shift_o = sck_rise & ~sel_s & ~sel_fall;
  assign first_o = shift_o & ~started_q;
  assign cap_o   = sck_fall & ~sel_s & ~sel_fall & started_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      gate_q    <= 1'b0;
    end else begin
      if (sel_fall)     started_q <= 1'b0;
      else if (shift_o) started_q <= 1'b1;

      if (sel_fall)      gate_q <= ~sck_s;
      else if (sck_rise) gate_q <= 1'b0;
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/fsp_shifter.sv
module fsp_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] par_i,
  input  logic         shift_i,
  input  logic         cap_i,
  input  logic         sdi_i,
  output logic         bit_o,
  output logic         flag_o
);
  logic [W-1:0] sr_q;
  logic         bit_q;
  logic         flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      bit_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (load_i) begin
      sr_q   <= par_i;
      flag_q <= |par_i;
      bit_q  <= |par_i;
    end else if (shift_i) begin
      bit_q <= sr_q[0];
      sr_q  <= {sr_q[W-1], sr_q[W-1:1]};
    end else if (cap_i) begin
      sr_q[W-1] <= sdi_i;
    end
  end

  assign bit_o  = bit_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/fault_scan_port.sv
module fault_scan_port #(
  parameter int unsigned N_CH        = 4,
  parameter int unsigned N_KIND      = fsp_pkg::FSP_KINDS,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned W          = N_CH * N_KIND
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flt_set_i,
  input  logic         sck_i,
  input  logic         sel_n_i,
  input  logic         sdi_i,
  output logic         sdo_o,
  output logic         sdo_en_o,
  output logic         gate_o
);
  // Synchronised serial pins, order {sdi, sel_n, sck}.
  logic [2:0] pins_s;
  logic       sck_s, sel_s, sdi_s;
  logic       sck_d, sel_d;
  logic       sck_rise, sck_fall, sel_fall;
  logic       gate, shift, cap, first_rise;
  logic       dbit, flag;
  logic [W-1:0] sticky;
  logic       sdo_q, en_q;

  fsp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sdi_i, sel_n_i, sck_i}),
    .q_o (pins_s)
  );

  assign sck_s = pins_s[0];
  assign sel_s = pins_s[1];
  assign sdi_s = pins_s[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      sel_d <= 1'b1;
    end else begin
      sck_d <= sck_s;
      sel_d <= sel_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign sel_fall = ~sel_s & sel_d;

  fsp_frame_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .sck_s    (sck_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .sel_s    (sel_s),
    .sel_fall (sel_fall),
    .gate_o   (gate),
    .shift_o  (shift),
    .cap_o    (cap),
    .first_o  (first_rise)
  );

  fsp_sticky #(.N_CH(N_CH), .N_KIND(N_KIND)) u_sticky (
    .clk   (clk),
    .rst   (rst),
    .set_i (flt_set_i),
    .clr_i (first_rise),
    .q_o   (sticky)
  );

  fsp_shifter #(.W(W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load_i  (sel_fall),
    .par_i   (sticky),
    .shift_i (shift),
    .cap_i   (cap),
    .sdi_i   (sdi_s),
    .bit_o   (dbit),
    .flag_o  (flag)
  );

  // Registered pin stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      sdo_q <= gate ? (flag | sdi_s) : dbit;
      en_q  <= ~sel_s;
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_en_o = en_q;
  assign gate_o   = gate;
endmodule

// File: rtl/fault_scan_port_chk.sv
module fault_scan_port_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         sck_s,
  input logic         sel_s,
  input logic         sck_rise,
  input logic         sel_fall,
  input logic         first_rise,
  input logic         gate,
  input logic         flag,
  input logic [W-1:0] sticky,
  input logic [W-1:0] set_i,
  input logic         sdo_en_o
);
  AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (!gate && !sdo_en_o && sticky == '0)); // R1
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !first_rise |=> ((sticky & $past(sticky)) == $past(sticky))); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sel_fall |=> $stable(flag)); // R3
  AST_GATE_SET_LOW: assert property (@(posedge clk) disable iff (rst)
    (sel_fall && !sck_s) |=> gate); // R4
  AST_GATE_BLOCKED_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sel_fall && sck_s) |=> !gate); // R5
  AST_GATE_CLR_RISE: assert property (@(posedge clk) disable iff (rst)
    (sck_rise && !sel_fall) |=> !gate); // R6
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    first_rise |=> (sticky == $past(set_i))); // R7
  AST_OE_DESELECT: assert property (@(posedge clk) disable iff (rst)
    sel_s |=> !sdo_en_o); // R9
  AST_OE_SELECT: assert property (@(posedge clk) disable iff (rst)
    !sel_s |=> sdo_en_o); // R9
endmodule

bind fault_scan_port fault_scan_port_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sck_s      (sck_s),
  .sel_s      (sel_s),
  .sck_rise   (sck_rise),
  .sel_fall   (sel_fall),
  .first_rise (first_rise),
  .gate       (gate),
  .flag       (flag),
  .sticky     (sticky),
  .set_i      (flt_set_i),
  .sdo_en_o   (sdo_en_o)
);

// File: tb/fault_scan_port_tb.sv
module fault_scan_port_tb;
  import fsp_pkg::*;

  localparam int W    = 16;
  localparam int HALF = 8;   // system cycles per serial half period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic sel_n = 1'b1;
  logic sdi = 1'b0;
  logic [W-1:0] flt = '0;
  logic sdo, sdo_en, gate;
  logic pin;

  always #5 clk = ~clk;

  fault_scan_port u_dut (
    .clk       (clk),
    .rst       (rst),
    .flt_set_i (flt),
    .sck_i     (sck),
    .sel_n_i   (sel_n),
    .sdi_i     (sdi),
    .sdo_o     (sdo),
    .sdo_en_o  (sdo_en),
    .gate_o    (gate)
  );

  // Open-drain pin with pull-up.
  assign pin = (sdo_en && !sdo) ? 1'b0 : 1'b1;

  // Scoreboard: sig 0 = pin, 1 = gate, 2 = enable.
  typedef struct {
    int    sig;
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  event smp_ev;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  initial begin
    forever begin
      @(smp_ev);
      while (q.size() > 0) begin
        exp_t e;
        logic act;
        e = q.pop_front();
        act = (e.sig == 0) ? pin : (e.sig == 1) ? gate : sdo_en;
        n_chk++;
        if (act !== e.val) begin
          n_fail++;
          $display("FAIL %s: got %b expected %b", e.tag, act, e.val);
        end
      end
    end
  end

  task automatic expect_sig(input int sig, input logic v, input string tag);
    exp_t e;
    e.sig = sig; e.val = v; e.tag = tag;
    q.push_back(e);
    -> smp_ev;
    @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic exp, input logic up, input string tag);
    sck = 1'b1; sdi = up;
    wait_n(HALF);
    expect_sig(0, exp, tag);
    sck = 1'b0;
    wait_n(HALF);
  endtask

  task automatic pulse_faults(input logic [W-1:0] v);
    flt = v;
    @(negedge clk);
    flt = '0;
    wait_n(4);
  endtask

  logic [W-1:0] pat_a;
  logic [3:0]   up_bits;

  initial begin
    pat_a = '0;
    pat_a[fsp_bit(0, FK_SHORT_SUP)] = 1'b1;
    pat_a[fsp_bit(1, FK_OVERTEMP)]  = 1'b1;
    pat_a[fsp_bit(3, FK_SHORT_GND)] = 1'b1;
    pat_a[fsp_bit(3, FK_OPEN)]      = 1'b1;
    up_bits = 4'b1011;

    @(negedge clk);
    wait_n(5);
    rst = 1'b0;
    wait_n(4);

    // R1 reset state
    expect_sig(2, 1'b0, "R1 enable after reset");
    expect_sig(1, 1'b0, "R1 gate after reset");
    expect_sig(0, 1'b1, "R1 pin released after reset");

    // Frame 1: faults A, upstream bits follow.
    pulse_faults(pat_a);
    wait_n(HALF);                                   // R2 held while idle
    sel_n = 1'b0;
    wait_n(HALF);
    expect_sig(2, 1'b1, "R9 enable while selected");
    expect_sig(1, 1'b1, "R4 gate set, clock low");
    expect_sig(0, 1'b1, "R3 flag for held faults (R2)");
    for (int k = 0; k < W; k++)
      clock_bit(pat_a[k], (k < 4) ? up_bits[k] : 1'b0, $sformatf("R6 field bit %0d", k));
    for (int k = 0; k < 4; k++)
      clock_bit(up_bits[k], 1'b0, $sformatf("R8 upstream bit %0d", k));
    sel_n = 1'b1;
    wait_n(HALF);
    expect_sig(2, 1'b0, "R9 enable off after deselect");
    expect_sig(0, 1'b1, "R9 pin released");

    // Frame 2: cleared register, OR pass-through, clear/set collision.
    sel_n = 1'b0;
    wait_n(HALF);
    expect_sig(0, 1'b0, "R7 flag clear after read");
    sdi = 1'b1;
    wait_n(HALF);
    expect_sig(0, 1'b1, "R4 upstream ORed into flag");
    sdi = 1'b0;
    wait_n(HALF);
    expect_sig(0, 1'b0, "R4 upstream low again");
    // First rising edge: set pulse lands in the clearing cycle (2 sync stages + 1).
    sck = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    flt[fsp_bit(2, FK_SHORT_SUP)] = 1'b1;
    @(negedge clk);
    flt = '0;
    wait_n(HALF - 2);
    expect_sig(1, 1'b0, "R6 gate cleared by first edge");
    expect_sig(0, 1'b0, "R6 field bit 0 frame 2");
    sck = 1'b0;
    wait_n(HALF);
    for (int k = 1; k < W; k++) begin
      if (k == 5) pulse_faults(16'h0001 << fsp_bit(0, FK_SHORT_GND));
      clock_bit(1'b0, 1'b0, $sformatf("R7 empty field bit %0d", k));
    end
    sel_n = 1'b1;
    wait_n(HALF);

    // Frame 3: faults from frame 2 must be present.
    sel_n = 1'b0;
    wait_n(HALF);
    expect_sig(0, 1'b1, "R7 flag shows kept faults");
    for (int k = 0; k < W; k++)
      clock_bit((k == fsp_bit(2, FK_SHORT_SUP)) || (k == fsp_bit(0, FK_SHORT_GND)),
                1'b0, $sformatf("R7 kept field bit %0d", k));
    sel_n = 1'b1;
    wait_n(HALF);

    // Frame 4: clock high at select fall blocks upstream.
    sck = 1'b1;
    wait_n(HALF);
    sdi = 1'b1;
    sel_n = 1'b0;
    wait_n(HALF);
    expect_sig(1, 1'b0, "R5 gate not set, clock high");
    expect_sig(0, 1'b0, "R5 upstream not passed");
    sdi = 1'b0;
    sck = 1'b0;
    wait_n(HALF);
    sel_n = 1'b1;
    wait_n(HALF);

    // Gate persists after deselect until the clock rises.
    sel_n = 1'b0;
    wait_n(HALF);
    sel_n = 1'b1;
    wait_n(HALF);
    expect_sig(1, 1'b1, "R9 gate kept after deselect");
    expect_sig(2, 1'b0, "R9 enable off with gate kept");
    sck = 1'b1;
    wait_n(HALF);
    expect_sig(1, 1'b0, "R9 gate cleared by clock rise");
    sck = 1'b0;
    wait_n(HALF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule